// File: doc/BRIEF.md
# Trigger fast command decoder

This block sits between the parallel output of a timing receiver and the backplane of a crate. Fast commands reach it in two formats. A short broadcast word is 6 bits wide: its low four bits select one of nine run-control commands, and its top two bits are user bits that carry no system meaning. An addressed command is a target crate address with an 8-bit sub-address and an 8-bit data byte. The block turns each recognised broadcast code into a one-cycle strobe. It copies the raw broadcast word, and the sub-address and data of each accepted addressed command, onto backplane bus registers that hold until they are next updated. It also drives the level-1 accept and BX0 on lines of their own.

A run-mode input picks normal running or stand-alone running. In normal running, addressed commands that come from this subsystem are refused, so the buses are not touched. In stand-alone running, every addressed command aimed at this crate is taken. Both command formats may be valid in the same cycle, and each is then handled on its own outputs. There is no state machine: every output is a registered function of the current inputs and the held bus values, so there are no states or transitions to name. One synchronous reset and a single 40 MHz clock drive all logic.

Top module: `fcmd_decoder`

## Requirements
- R1: While `rst` is high, every strobe, pulse and line output is 0 on the following cycle. A clock edge with `rst` high clears `bus_bcast`, `bus_sub` and `bus_data` to 0.
- R2: A broadcast command with `bc_valid` high and low nibble `bc_word[3:0]` = k, where k is 1 to 9, raises only `cmd_stb[k-1]` for exactly the one cycle after the edge that sampled it. The order is: bit0 L1 reset, bit1 hard reset, bit2 start trigger, bit3 stop trigger, bit4 test enable, bit5 private gap, bit6 private orbit, bit7 BX0, bit8 bunch counter reset.
- R3: Low-nibble codes 0 and 10 to 15 raise no strobe, and they still update the broadcast bus.
- R4: The user bits `bc_word[5:4]` have no effect on which strobe fires. They appear unchanged on `bus_bcast[5:4]`.
- R5: On a valid broadcast, `bus_bcast` takes the word one cycle later and `bc_upd` pulses for that one cycle. With no valid broadcast, `bus_bcast` keeps its value.
- R6: An addressed command is accepted only when `ad_target` equals `crate_id`. When it is accepted, `bus_sub` and `bus_data` take the sub-address and data one cycle later and `ad_upd` pulses for one cycle. Otherwise both buses hold and `ad_upd` stays 0.
- R7: When `run_normal` = 1, a command with `ad_local` = 1 is refused. When `run_normal` = 0, `ad_local` has no effect on acceptance.
- R8: `l1a_line` repeats `l1a_in` one cycle later. `bx0_line` is high exactly when the BX0 strobe `cmd_stb[7]` is high.
- R9: A valid broadcast and a valid addressed command in the same cycle are both processed in that one cycle.
- R10: A valid broadcast on consecutive cycles gives a strobe on each following cycle. A single command never gives a strobe longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock from the timing receiver |
| rst | input | 1 | Synchronous reset, active high |
| run_normal | input | 1 | 1 = normal running, 0 = stand-alone |
| crate_id | input | 8 | Address of this crate |
| l1a_in | input | 1 | Level-1 accept from the receiver |
| bc_valid | input | 1 | Broadcast word valid |
| bc_word | input | 6 | Broadcast word, bits 5:4 user, bits 3:0 code |
| ad_valid | input | 1 | Addressed command valid |
| ad_target | input | 8 | Target crate address |
| ad_sub | input | 8 | Sub-address |
| ad_data | input | 8 | Data byte |
| ad_local | input | 1 | Command originates from this subsystem |
| cmd_stb | output | 9 | One-cycle run-control strobes |
| bus_bcast | output | 6 | Held broadcast bus |
| bc_upd | output | 1 | Broadcast bus update pulse |
| bus_sub | output | 8 | Held sub-address bus |
| bus_data | output | 8 | Held data bus |
| ad_upd | output | 1 | Addressed bus update pulse |
| l1a_line | output | 1 | Level-1 accept bus line |
| bx0_line | output | 1 | BX0 bus line |

## Verification
Every result sits behind exactly one register. A strobe, update pulse, bus value or line level caused by inputs sampled at one rising edge appears just after that edge and lasts until the next one. The bench changes inputs 2 ns after a rising edge. In the same step it computes the expected outputs from those inputs and from its own copy of the held bus values. It compares all outputs 2 ns after the next rising edge, on every cycle. Refused or idle commands are therefore checked on the very cycle in which a wrong update would appear.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    localparam int CODE_W = 4;
    localparam int NCMD   = 9;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE   = 4'd0,
        CODE_L1RST  = 4'd1,
        CODE_HARD   = 4'd2,
        CODE_START  = 4'd3,
        CODE_STOP   = 4'd4,
        CODE_TEST   = 4'd5,
        CODE_PGAP   = 4'd6,
        CODE_PORBIT = 4'd7,
        CODE_BX0    = 4'd8,
        CODE_BCRST  = 4'd9
    } run_code_e;

    localparam int BX0_IDX = 7;

    function automatic logic [NCMD-1:0] decode_code(input logic [CODE_W-1:0] c);
        logic [NCMD-1:0] s;
        s = '0;
        unique case (c)
            CODE_L1RST:  s[0] = 1'b1;
            CODE_HARD:   s[1] = 1'b1;
            CODE_START:  s[2] = 1'b1;
            CODE_STOP:   s[3] = 1'b1;
            CODE_TEST:   s[4] = 1'b1;
            CODE_PGAP:   s[5] = 1'b1;
            CODE_PORBIT: s[6] = 1'b1;
            CODE_BX0:    s[7] = 1'b1;
            CODE_BCRST:  s[8] = 1'b1;
            default:     s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/fcmd_bcast.sv
module fcmd_bcast
    import fcmd_pkg::*;
#(
    parameter int BC_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bc_valid,
    input  logic [BC_W-1:0]      bc_word,
    output logic [NCMD-1:0]      cmd_stb,
    output logic [BC_W-1:0]      bus_bcast,
    output logic                 bc_upd
);
    logic [NCMD-1:0] stb_next;

    always_comb begin
        stb_next = bc_valid ? decode_code(bc_word[CODE_W-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb   <= '0;
            bus_bcast <= '0;
            bc_upd    <= 1'b0;
        end else begin
            cmd_stb <= stb_next;
            bc_upd  <= bc_valid;
            if (bc_valid) begin
                bus_bcast <= bc_word;
            end
        end
    end

    // R2
    onehot_stb_chk: assert property (@(posedge clk) $onehot0(cmd_stb));

    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(bc_valid) && !$past(rst)) |-> $stable(bus_bcast));

    generate
        for (genvar i = 0; i < NCMD; i++) begin : g_stb_chk
            // R2
            stb_source_chk: assert property (@(posedge clk) disable iff (rst)
                cmd_stb[i] |-> ($past(bc_valid) && ($past(bc_word[CODE_W-1:0]) == CODE_W'(i + 1))));
        end
    endgenerate
endmodule

// File: rtl/fcmd_addr.sv
module fcmd_addr #(
    parameter int AD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_normal,
    input  logic [AD_W-1:0] crate_id,
    input  logic            ad_valid,
    input  logic [AD_W-1:0] ad_target,
    input  logic [AD_W-1:0] ad_sub,
    input  logic [AD_W-1:0] ad_data,
    input  logic            ad_local,
    output logic [AD_W-1:0] bus_sub,
    output logic [AD_W-1:0] bus_data,
    output logic            ad_upd
);
    logic hit;
    logic blocked;
    logic take;

    always_comb begin
        hit     = (ad_target == crate_id);
        blocked = run_normal && ad_local;
        take    = ad_valid && hit && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_sub  <= '0;
            bus_data <= '0;
            ad_upd   <= 1'b0;
        end else begin
            ad_upd <= take;
            if (take) begin
                bus_sub  <= ad_sub;
                bus_data <= ad_data;
            end
        end
    end

    // R6
    addr_match_chk: assert property (@(posedge clk) disable iff (rst)
        ad_upd |-> ($past(ad_target) == $past(crate_id)));

    // R7
    normal_block_chk: assert property (@(posedge clk) disable iff (rst)
        ad_upd |-> !($past(run_normal) && $past(ad_local)));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ad_upd && !$past(rst)) |-> $stable(bus_data));
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int BC_W = 6,
    parameter int AD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_normal,
    input  logic [AD_W-1:0] crate_id,
    input  logic            l1a_in,
    input  logic            bc_valid,
    input  logic [BC_W-1:0] bc_word,
    input  logic            ad_valid,
    input  logic [AD_W-1:0] ad_target,
    input  logic [AD_W-1:0] ad_sub,
    input  logic [AD_W-1:0] ad_data,
    input  logic            ad_local,
    output logic [NCMD-1:0] cmd_stb,
    output logic [BC_W-1:0] bus_bcast,
    output logic            bc_upd,
    output logic [AD_W-1:0] bus_sub,
    output logic [AD_W-1:0] bus_data,
    output logic            ad_upd,
    output logic            l1a_line,
    output logic            bx0_line
);
    fcmd_bcast #(.BC_W(BC_W)) u_bcast (
        .clk       (clk),
        .rst       (rst),
        .bc_valid  (bc_valid),
        .bc_word   (bc_word),
        .cmd_stb   (cmd_stb),
        .bus_bcast (bus_bcast),
        .bc_upd    (bc_upd)
    );

    fcmd_addr #(.AD_W(AD_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .run_normal (run_normal),
        .crate_id   (crate_id),
        .ad_valid   (ad_valid),
        .ad_target  (ad_target),
        .ad_sub     (ad_sub),
        .ad_data    (ad_data),
        .ad_local   (ad_local),
        .bus_sub    (bus_sub),
        .bus_data   (bus_data),
        .ad_upd     (ad_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            l1a_line <= 1'b0;
        end else begin
            l1a_line <= l1a_in;
        end
    end

    always_comb begin
        bx0_line = cmd_stb[BX0_IDX];
    end

    // R8
    l1a_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (l1a_line == $past(l1a_in)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (cmd_stb == '0 && !bc_upd && !ad_upd && !l1a_line));
endmodule

// File: tb/tb_fcmd_decoder.sv
module tb_fcmd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_normal = 1'b0;
    logic [7:0] crate_id = 8'h3C;
    logic       l1a_in = 1'b0;
    logic       bc_valid = 1'b0;
    logic [5:0] bc_word = '0;
    logic       ad_valid = 1'b0;
    logic [7:0] ad_target = '0;
    logic [7:0] ad_sub = '0;
    logic [7:0] ad_data = '0;
    logic       ad_local = 1'b0;

    logic [8:0] cmd_stb;
    logic [5:0] bus_bcast;
    logic       bc_upd;
    logic [7:0] bus_sub;
    logic [7:0] bus_data;
    logic       ad_upd;
    logic       l1a_line;
    logic       bx0_line;

    int tests = 0;
    int fails = 0;

    logic [5:0] m_bcast = '0;
    logic [7:0] m_sub = '0;
    logic [7:0] m_data = '0;

    always #5 clk = ~clk;

    fcmd_decoder dut (
        .clk(clk), .rst(rst), .run_normal(run_normal), .crate_id(crate_id),
        .l1a_in(l1a_in), .bc_valid(bc_valid), .bc_word(bc_word),
        .ad_valid(ad_valid), .ad_target(ad_target), .ad_sub(ad_sub),
        .ad_data(ad_data), .ad_local(ad_local), .cmd_stb(cmd_stb),
        .bus_bcast(bus_bcast), .bc_upd(bc_upd), .bus_sub(bus_sub),
        .bus_data(bus_data), .ad_upd(ad_upd), .l1a_line(l1a_line),
        .bx0_line(bx0_line)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: predict from current inputs, then compare after the edge
    task automatic step(input string tag);
        logic [8:0] e_cmd;
        logic       e_bupd, e_aupd, e_l1a;
        int         code;
        e_cmd = '0; e_bupd = 0; e_aupd = 0; e_l1a = 0;
        if (rst) begin
            m_bcast = '0; m_sub = '0; m_data = '0;
        end else begin
            code = int'(bc_word[3:0]);
            if (bc_valid) begin
                if (code >= 1 && code <= 9) e_cmd = 9'(1) << (code - 1);
                m_bcast = bc_word;
                e_bupd = 1;
            end
            if (ad_valid && ad_target == crate_id && !(run_normal && ad_local)) begin
                m_sub = ad_sub; m_data = ad_data; e_aupd = 1;
            end
            e_l1a = l1a_in;
        end
        @(posedge clk); #2;
        chk(tag, "cmd_stb",   32'(cmd_stb),   32'(e_cmd));
        chk(tag, "bus_bcast", 32'(bus_bcast), 32'(m_bcast));
        chk(tag, "bc_upd",    32'(bc_upd),    32'(e_bupd));
        chk(tag, "bus_sub",   32'(bus_sub),   32'(m_sub));
        chk(tag, "bus_data",  32'(bus_data),  32'(m_data));
        chk(tag, "ad_upd",    32'(ad_upd),    32'(e_aupd));
        chk(tag, "l1a_line",  32'(l1a_line),  32'(e_l1a));
        chk(tag, "bx0_line",  32'(bx0_line),  32'(e_cmd[7]));
    endtask

    task automatic idle();
        bc_valid = 0; ad_valid = 0; l1a_in = 0;
    endtask

    task automatic send_ad(input logic [7:0] tgt, input logic [7:0] s,
                           input logic [7:0] d, input logic loc);
        ad_valid = 1; ad_target = tgt; ad_sub = s; ad_data = d; ad_local = loc;
    endtask

    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2;
        // R1: commands during reset give nothing
        bc_valid = 1; bc_word = 6'h01; l1a_in = 1;
        send_ad(8'h3C, 8'h11, 8'h22, 0);
        for (int i = 0; i < 3; i++) step("R1 in reset");
        rst = 0; idle();
        step("R1 idle after reset");
        // R2: every run code
        for (int k = 1; k <= 9; k++) begin
            bc_valid = 1; bc_word = 6'(k);
            step("R2 code");
        end
        idle(); step("R2 strobe ends");
        // R3: unused codes
        bc_valid = 1; bc_word = 6'h00; step("R3 code 0");
        for (int k = 10; k <= 15; k++) begin
            bc_word = 6'(k); step("R3 unused code");
        end
        // R4: user bits
        bc_word = 6'h13; step("R4 user 01");
        bc_word = 6'h23; step("R4 user 10");
        bc_word = 6'h38; step("R4 user 11 bx0");
        // R5: hold
        idle(); step("R5 hold"); step("R5 hold");
        // R10: back to back
        bc_valid = 1; bc_word = 6'h04; step("R10 first");
        step("R10 second");
        idle(); step("R10 ends");
        // R6: address match and mismatch
        run_normal = 0;
        send_ad(8'h3C, 8'hA5, 8'h5A, 0); step("R6 match");
        send_ad(8'h3D, 8'hFF, 8'hEE, 0); step("R6 mismatch");
        idle(); step("R6 hold");
        // R7: mode gate
        send_ad(8'h3C, 8'h12, 8'h34, 1); step("R7 standalone local");
        run_normal = 1;
        send_ad(8'h3C, 8'h56, 8'h78, 1); step("R7 normal local refused");
        send_ad(8'h3C, 8'h9A, 8'hBC, 0); step("R7 normal remote");
        idle(); step("R7 hold");
        // R8: l1a and bx0 lines
        l1a_in = 1; step("R8 l1a");
        l1a_in = 0; step("R8 l1a drop");
        l1a_in = 1; step("R8 l1a");
        step("R8 l1a held");
        idle(); bc_valid = 1; bc_word = 6'h08; step("R8 bx0");
        // R9: both formats together
        run_normal = 0;
        bc_valid = 1; bc_word = 6'h29; send_ad(8'h3C, 8'h01, 8'hC3, 1);
        l1a_in = 1; step("R9 simultaneous");
        idle(); step("R9 ends");
        // R1: reset mid run clears buses
        rst = 1; bc_valid = 1; bc_word = 6'h02; step("R1 reset again");
        rst = 0; idle(); step("R1 cleared");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule